// File: doc/BRIEF.md
# Dual-Controller Interrupt and Mailbox Unit

This block sits between two bus controllers that share one downstream bus. For each controller it keeps a set of sticky interrupt status bits, a mask register and an active-low interrupt line. Seven sources feed each controller's status bits: lock grant, bus lost, inbox full, outbox emptied, a self-test request, downstream bus hung and an external interrupt input. The grant and loss indications come from the bus arbitration logic, which is outside this block. Each controller gets its own pair of these two inputs, while the hung and external indications go to both controllers.

The block also provides two 16-bit one-deep mailboxes, one for each direction. A controller posts a word into its outbox, and that word appears in the other controller's inbox. When the receiver reads its inbox, the slot empties and the sender is told through an interrupt event. Each side reaches its registers through plain write and read strobes with an address, and read data is returned in the same cycle. The access port has no valid/ready back-pressure: a post to an occupied outbox is simply dropped. The sender can avoid this by checking its flags word first.

Register addresses, which are the same on both sides: 0 status (write 1 to clear), 1 mask, 2 self-test trigger (write-only, reads 0), 3 outbox (write-only, reads 0), 4 inbox (read; a read with the read strobe consumes the word), 5 flags (read-only). Status and mask bit positions: 0 lock grant, 1 bus lost, 2 inbox full, 3 outbox emptied, 4 self-test, 5 bus hung, 6 external input. Flags bit 0 means the inbox holds a word, and flags bit 1 means the outbox is free.

Top module: `irq_mbox_unit`

## Requirements
- R1: After reset, both status registers read 0, both mask registers read 0x7F, flags read 0x0002 on both sides, and both `irq_n` outputs are high.
- R2: A status bit is set on the rising edge of its source, one clock after the edge is sampled. A source that stays high does not set the bit again after the bit has been cleared.
- R3: Writing 1 to a status bit at address 0 clears it, and writing 0 leaves it unchanged. If a source event arrives in the same cycle as the clear, the set wins.
- R4: A mask bit of 1 blocks its status bit from the interrupt line, and a mask bit of 0 lets it through. `irq_n[s]` is low exactly while side s has a set status bit whose mask bit is 0.
- R5: Writing 1 in bit 0 at address 2 sets status bit 4 of the writing side only. Writing 0 there has no effect.
- R6: The external input (bit 6) and bus hung (bit 5) set the status bits of both sides. Lock grant (bit 0) and bus lost (bit 1) set only the status of the side whose input rose.
- R7: A write to an empty outbox stores the word. It sets the receiver's flags bit 0 and status bit 2, and it clears the sender's flags bit 1.
- R8: A strobed read of a full inbox returns the stored word and empties the slot. It sets the sender's flags bit 1 and status bit 3.
- R9: A write to a full outbox is ignored, and the earlier word is the one delivered.
- R10: A strobed read of an empty inbox does not change any status or flags bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 2 | Write strobe, one bit per side |
| reg_rd | input | 2 | Read strobe, one bit per side; consumes the inbox at address 4 |
| reg_addr | input | 2x3 | Register address per side |
| reg_wdata | input | 2x16 | Write data per side |
| reg_rdata | output | 2x16 | Combinational read data per side |
| grant_i | input | 2 | Lock-grant level per side from the arbiter |
| lost_i | input | 2 | Bus-lost level per side from the arbiter |
| bus_hung_i | input | 1 | Downstream bus hung level, shared |
| ext_irq_i | input | 1 | External interrupt level, shared |
| irq_n | output | 2 | Active-low interrupt per side |

## Verification
Most internal faults show up on a port within one or two clocks. A status bit that is wrong appears at the next status read, and it also appears on `irq_n` as soon as its mask bit is opened. Mailbox occupancy has two outputs: the flags word of the sender and the flags word of the receiver. So if the slot's full bit is lost or stuck, the two flags words disagree with the sequence of posts and reads at the very next access. An edge detector that has turned into a level detector shows up only when a bit is cleared while its source is still high, so the bench performs exactly that clear.

// File: rtl/irqmb_pkg.sv
package irqmb_pkg;
  localparam int NSRC   = 7;
  localparam int ADDR_W = 3;

  // status / mask bit positions
  localparam int B_GRANT = 0;
  localparam int B_LOST  = 1;
  localparam int B_FULL  = 2;
  localparam int B_EMPTY = 3;
  localparam int B_TEST  = 4;
  localparam int B_HUNG  = 5;
  localparam int B_EXT   = 6;

  // register addresses
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TEST   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUTBOX = 3'd3;
  localparam logic [ADDR_W-1:0] A_INBOX  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;
endpackage

// File: rtl/rise_det.sv
module rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [DATA_W-1:0] post_data,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              filled,
  output logic              drained
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  assign filled  = post && !full_q;
  assign drained = take && full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (filled) data_q <= post_data;
      if (filled)       full_q <= 1'b1;
      else if (drained) full_q <= 1'b0;
    end
  end

  assign data = data_q;
  assign full = full_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] event_p,
  input  logic            clr_en,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_en,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq_n
);
  logic [NSRC-1:0] status_q, mask_q, clr_vec;

  assign clr_vec = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_vec) | event_p;
      if (mask_en) mask_q <= mask_bits;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq_n  = ~|(status_q & ~mask_q);
endmodule

// File: rtl/irq_mbox_unit.sv
module irq_mbox_unit
  import irqmb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  reg_wr,
  input  logic [1:0]                  reg_rd,
  input  logic [1:0][ADDR_W-1:0]      reg_addr,
  input  logic [1:0][DATA_W-1:0]      reg_wdata,
  output logic [1:0][DATA_W-1:0]      reg_rdata,
  input  logic [1:0]                  grant_i,
  input  logic [1:0]                  lost_i,
  input  logic                        bus_hung_i,
  input  logic                        ext_irq_i,
  output logic [1:0]                  irq_n
);
  localparam int NLVL = 6;

  logic [NLVL-1:0]             lvl_vec, lvl_rise;
  logic [1:0]                  mb_post, mb_take, mb_full, mb_fill, mb_drain;
  logic [1:0][DATA_W-1:0]      mb_data;
  logic [1:0][NSRC-1:0]        ev_vec, st_vec, mk_vec;

  // level sources: {ext, hung, lost[1:0], grant[1:0]}
  assign lvl_vec = {ext_irq_i, bus_hung_i, lost_i, grant_i};

  rise_det #(.W(NLVL)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_vec),
    .rise (lvl_rise)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int PEER = 1 - s;

    // slot s carries words from side s to side PEER
    assign mb_post[s] = reg_wr[s]   && (reg_addr[s]    == A_OUTBOX);
    assign mb_take[s] = reg_rd[PEER] && (reg_addr[PEER] == A_INBOX);

    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .post     (mb_post[s]),
      .post_data(reg_wdata[s]),
      .take     (mb_take[s]),
      .data     (mb_data[s]),
      .full     (mb_full[s]),
      .filled   (mb_fill[s]),
      .drained  (mb_drain[s])
    );

    always_comb begin
      ev_vec[s]          = '0;
      ev_vec[s][B_GRANT] = lvl_rise[s];
      ev_vec[s][B_LOST]  = lvl_rise[2+s];
      ev_vec[s][B_FULL]  = mb_fill[PEER];
      ev_vec[s][B_EMPTY] = mb_drain[s];
      ev_vec[s][B_TEST]  = reg_wr[s] && (reg_addr[s] == A_TEST) && reg_wdata[s][0];
      ev_vec[s][B_HUNG]  = lvl_rise[4];
      ev_vec[s][B_EXT]   = lvl_rise[5];
    end

    irq_bank #(.NSRC(NSRC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_p  (ev_vec[s]),
      .clr_en   (reg_wr[s] && (reg_addr[s] == A_STATUS)),
      .clr_bits (reg_wdata[s][NSRC-1:0]),
      .mask_en  (reg_wr[s] && (reg_addr[s] == A_MASK)),
      .mask_bits(reg_wdata[s][NSRC-1:0]),
      .status   (st_vec[s]),
      .mask     (mk_vec[s]),
      .irq_n    (irq_n[s])
    );

    always_comb begin
      reg_rdata[s] = '0;
      case (reg_addr[s])
        A_STATUS: reg_rdata[s][NSRC-1:0] = st_vec[s];
        A_MASK:   reg_rdata[s][NSRC-1:0] = mk_vec[s];
        A_INBOX:  reg_rdata[s]           = mb_data[PEER];
        A_FLAGS:  reg_rdata[s][1:0]      = {~mb_full[s], mb_full[PEER]};
        default:  reg_rdata[s]           = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqmb_checker.sv
module irqmb_checker
  import irqmb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             reg_wr,
  input logic [1:0][ADDR_W-1:0] reg_addr,
  input logic [1:0][DATA_W-1:0] reg_wdata,
  input logic                   ext_irq_i,
  input logic [1:0]             mb_full,
  input logic [1:0][DATA_W-1:0] mb_data,
  input logic [1:0][NSRC-1:0]   st_vec,
  input logic [1:0][NSRC-1:0]   mk_vec,
  input logic [1:0]             irq_n
);
  AST_EXT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_irq_i) |=> (st_vec[0][B_EXT] && st_vec[1][B_EXT])); // R6

  for (genvar s = 0; s < 2; s++) begin : g_chk
    localparam int PEER = 1 - s;

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_full[s] && reg_wr[s] && reg_addr[s] == A_OUTBOX) |=> $stable(mb_data[s])); // R9

    AST_FILL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mb_full[s]) |-> st_vec[PEER][B_FULL]); // R7

    AST_DRAIN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mb_full[s]) |-> st_vec[s][B_EMPTY]); // R8

    AST_TEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr[s] && reg_addr[s] == A_TEST && !reg_wdata[s][0] && !st_vec[s][B_TEST])
      |=> !st_vec[s][B_TEST]); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&mk_vec[s]) |-> irq_n[s]); // R4
  end
endmodule

bind irq_mbox_unit irqmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .ext_irq_i(ext_irq_i),
  .mb_full  (mb_full),
  .mb_data  (mb_data),
  .st_vec   (st_vec),
  .mk_vec   (mk_vec),
  .irq_n    (irq_n)
);

// File: tb/tb_irq_mbox_unit.sv
`timescale 1ns/1ps
module tb_irq_mbox_unit;
  import irqmb_pkg::*;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [1:0]             reg_wr = '0, reg_rd = '0;
  logic [1:0][ADDR_W-1:0] reg_addr = '0;
  logic [1:0][15:0]       reg_wdata = '0;
  logic [1:0][15:0]       reg_rdata;
  logic [1:0]             grant_i = '0, lost_i = '0;
  logic                   bus_hung_i = 1'b0, ext_irq_i = 1'b0;
  logic [1:0]             irq_n;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_mbox_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grant_i(grant_i), .lost_i(lost_i), .bus_hung_i(bus_hung_i),
    .ext_irq_i(ext_irq_i), .irq_n(irq_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int side, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr[side] = 1'b1; reg_addr[side] = a; reg_wdata[side] = d;
    @(negedge clk);
    reg_wr[side] = 1'b0;
  endtask

  task automatic rd(int side, logic [2:0] a, bit consume, output logic [15:0] v);
    @(negedge clk);
    reg_addr[side] = a; reg_rd[side] = consume;
    #1 v = reg_rdata[side];
    @(negedge clk);
    reg_rd[side] = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int s = 0; s < 2; s++) begin
      rd(s, A_STATUS, 0, v); check("R1 status", v, 0);
      rd(s, A_MASK, 0, v);   check("R1 mask", v, 16'h7F);
      rd(s, A_FLAGS, 0, v);  check("R1 flags", v, 16'h2);
    end
    check("R1 irq_n", irq_n, 2'b11);
  endtask

  task automatic t_edge_mask_clear();
    logic [15:0] v;
    @(negedge clk); grant_i[0] = 1'b1;
    settle();
    rd(0, A_STATUS, 0, v); check("R2 grant sets bit0", v, 16'h1);
    rd(1, A_STATUS, 0, v); check("R6 grant other side untouched", v, 0);
    check("R4 masked keeps irq high", irq_n[0], 1'b1);
    wr(0, A_MASK, 16'h7E);
    #1 check("R4 unmasked drives irq low", irq_n[0], 1'b0);
    wr(0, A_STATUS, 16'h0001);
    rd(0, A_STATUS, 0, v); check("R3 W1C clears", v, 0);
    check("R4 irq released", irq_n[0], 1'b1);
    settle();
    rd(0, A_STATUS, 0, v); check("R2 held level no re-set", v, 0);
    @(negedge clk); grant_i[0] = 1'b0; lost_i[0] = 1'b1;
    settle();
    wr(0, A_STATUS, 16'h0000);
    rd(0, A_STATUS, 0, v); check("R3 write 0 keeps", v, 16'h2);
    wr(0, A_STATUS, 16'h0002);
    rd(0, A_STATUS, 0, v); check("R3 W1C lost", v, 0);
    @(negedge clk); lost_i[0] = 1'b0;
    wr(0, A_MASK, 16'h7F);
  endtask

  task automatic t_test();
    logic [15:0] v;
    wr(1, A_TEST, 16'h0000);
    rd(1, A_STATUS, 0, v); check("R5 test write 0 no effect", v, 0);
    wr(1, A_TEST, 16'h0001);
    rd(1, A_STATUS, 0, v); check("R5 test write 1 sets", v, 16'h10);
    rd(0, A_STATUS, 0, v); check("R5 other side untouched", v, 0);
    wr(1, A_STATUS, 16'h0010);
  endtask

  task automatic t_shared();
    logic [15:0] v;
    @(negedge clk); ext_irq_i = 1'b1; bus_hung_i = 1'b1;
    settle();
    rd(0, A_STATUS, 0, v); check("R6 shared side0", v, 16'h60);
    rd(1, A_STATUS, 0, v); check("R6 shared side1", v, 16'h60);
    @(negedge clk); ext_irq_i = 1'b0; bus_hung_i = 1'b0; lost_i[1] = 1'b1;
    settle();
    rd(1, A_STATUS, 0, v); check("R6 lost side1", v, 16'h62);
    rd(0, A_STATUS, 0, v); check("R6 lost not side0", v, 16'h60);
    @(negedge clk); lost_i[1] = 1'b0;
    wr(0, A_STATUS, 16'h7F);
    wr(1, A_STATUS, 16'h7F);
  endtask

  task automatic t_mbox();
    logic [15:0] v;
    wr(1, A_MASK, 16'h7B);
    wr(0, A_OUTBOX, 16'hBEEF);
    rd(1, A_FLAGS, 0, v);  check("R7 receiver inbox full", v[0], 1'b1);
    rd(1, A_STATUS, 0, v); check("R7 receiver full status", v, 16'h4);
    check("R4 full unmasked irq", irq_n[1], 1'b0);
    rd(0, A_FLAGS, 0, v);  check("R7 sender outbox busy", v[1], 1'b0);
    wr(0, A_OUTBOX, 16'h1234);
    rd(1, A_INBOX, 1, v);  check("R9 full write ignored / R8 data", v, 16'hBEEF);
    rd(0, A_FLAGS, 0, v);  check("R8 sender outbox free", v[1], 1'b1);
    rd(0, A_STATUS, 0, v); check("R8 sender empty status", v, 16'h8);
    rd(1, A_FLAGS, 0, v);  check("R8 inbox drained", v[0], 1'b0);
    wr(0, A_STATUS, 16'h7F);
    rd(1, A_INBOX, 1, v);
    rd(0, A_STATUS, 0, v); check("R10 empty read no event", v, 0);
    rd(0, A_FLAGS, 0, v);  check("R10 flags unchanged", v, 16'h2);
    wr(1, A_OUTBOX, 16'h5A5A);
    rd(0, A_INBOX, 1, v);  check("R8 reverse direction data", v, 16'h5A5A);
    rd(1, A_STATUS, 0, v); check("R8 reverse empty status", v, 16'hC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge_mask_clear();
    t_test();
    t_shared();
    t_mbox();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule